// File: doc/BRIEF.md
# Per-Threshold Candidate Multiplicity Counter

This block counts, once per bunch crossing, how many candidates passed each of six momentum threshold levels. Every crossing it receives one threshold code and one suppress flag for each of 26 candidate inputs. A candidate whose flag is set has already been found to duplicate one seen by a neighbouring input, so it is left out. That way one particle is not counted twice.

The counting is cumulative. A candidate with a higher code also counts toward every lower level. Each level's total goes into a 3-bit field that saturates instead of wrapping. The six fields are packed into one 18-bit word that feeds a downstream adder tree. The word and a valid strobe leave a register stage two clocks after the inputs are sampled.

Top module: `thr_mult_counter`

## Requirements
- R1: A synchronous active-high reset clears the output word and the valid strobe. Both read zero on the first clock after a reset edge.
- R2: The valid strobe and the word that belongs to a crossing appear exactly two clocks after that crossing's inputs are sampled. There is one result per clock with no gaps.
- R3: A candidate with code k, where 1 <= k <= 6, adds one to the count of every level from 1 through k.
- R4: Code 0 and code 7 add nothing to any level.
- R5: A candidate whose suppress flag is 1 adds nothing, whatever its code.
- R6: Each level count saturates at 7 when more than seven candidates reach that level.
- R7: The count for level n (1 to 6) is placed in word bits [3n-1:3n-3], so level 1 sits in bits [2:0] and level 6 in bits [17:15].
- R8: A crossing sampled with in_valid low yields a word of zero with valid low, whatever its codes and flags.
- R9: No level count is larger than the count of the level below it.
- R10: Each crossing is counted on its own. Nothing carries over from one crossing to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Candidate inputs hold a crossing this cycle |
| cand_code | input | 78 | 26 threshold codes, 3 bits each; candidate c in bits [3c+2:3c] |
| cand_sup | input | 26 | Suppress flag per candidate, 1 = skip |
| mult_word | output | 18 | Six saturating 3-bit level counts |
| mult_valid | output | 1 | Marks mult_word as holding a crossing result |

## Verification
The bench goes after the following corner cases:
- **Code 7 and code 0 (R4).** A design that compares only against the lower bound of each level would count code 7 on every level.
- **Full saturation (R6).** All 26 candidates at code 6 must give 7 on every level. A wrapping counter would show 2 instead.
- **Suppression (R5).** Every input is at code 6 and all but a few are suppressed. This catches a mask applied to the wrong candidate or left off.
- **Data with in_valid low (R8).** Nonzero codes arrive while in_valid is low. A design that gates only the strobe would leak these counts.
- **Latency and packing (R2, R7).** Back-to-back random crossings would expose an off-by-one latency, a stale count carried over, or fields packed in reverse order.

// File: rtl/mtc_pkg.sv
package mtc_pkg;
  parameter int unsigned DEF_NUM_CAND = 26;
  parameter int unsigned DEF_NUM_LVL  = 6;
  parameter int unsigned DEF_CODE_W   = 3;
  parameter int unsigned DEF_CNT_W    = 3;

  function automatic int unsigned sum_width(input int unsigned n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/mtc_cand_decode.sv
module mtc_cand_decode #(
  parameter int unsigned NUM_LVL = mtc_pkg::DEF_NUM_LVL,
  parameter int unsigned CODE_W  = mtc_pkg::DEF_CODE_W
) (
  input  logic               live,
  input  logic               sup,
  input  logic [CODE_W-1:0]  code,
  output logic [NUM_LVL-1:0] therm
);
  logic in_range;
  assign in_range = (int'(code) >= 1) && (int'(code) <= int'(NUM_LVL));

  for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
    assign therm[l] = live && !sup && in_range && (int'(code) >= l + 1);
  end
endmodule

// File: rtl/mtc_level_count.sv
module mtc_level_count #(
  parameter int unsigned NUM_CAND = mtc_pkg::DEF_NUM_CAND,
  parameter int unsigned SUM_W    = mtc_pkg::sum_width(NUM_CAND)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_CAND-1:0] hits,
  output logic [SUM_W-1:0]    sum_q
);
  logic [SUM_W-1:0] sum_d;

  always_comb begin
    sum_d = '0;
    for (int i = 0; i < NUM_CAND; i++) begin
      sum_d = sum_d + SUM_W'(hits[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) sum_q <= '0;
    else     sum_q <= sum_d;
  end
endmodule

// File: rtl/mtc_saturate.sv
module mtc_saturate #(
  parameter int unsigned SUM_W = 5,
  parameter int unsigned CNT_W = mtc_pkg::DEF_CNT_W
) (
  input  logic [SUM_W-1:0] raw,
  output logic [CNT_W-1:0] cnt
);
  localparam int unsigned CNT_MAX = (1 << CNT_W) - 1;

  if (SUM_W > CNT_W) begin : g_clamp
    assign cnt = (raw > SUM_W'(CNT_MAX)) ? CNT_W'(CNT_MAX) : raw[CNT_W-1:0];
  end else begin : g_pass
    assign cnt = CNT_W'(raw);
  end
endmodule

// File: rtl/thr_mult_counter.sv
module thr_mult_counter #(
  parameter int unsigned NUM_CAND = mtc_pkg::DEF_NUM_CAND,
  parameter int unsigned NUM_LVL  = mtc_pkg::DEF_NUM_LVL,
  parameter int unsigned CODE_W   = mtc_pkg::DEF_CODE_W,
  parameter int unsigned CNT_W    = mtc_pkg::DEF_CNT_W
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  input  logic [NUM_CAND*CODE_W-1:0] cand_code,
  input  logic [NUM_CAND-1:0]        cand_sup,
  output logic [NUM_LVL*CNT_W-1:0]   mult_word,
  output logic                       mult_valid
);
  localparam int unsigned SUM_W  = mtc_pkg::sum_width(NUM_CAND);
  localparam int unsigned WORD_W = NUM_LVL * CNT_W;

  logic [NUM_LVL-1:0]  therm    [NUM_CAND];
  logic [NUM_CAND-1:0] lvl_hits [NUM_LVL];
  logic [SUM_W-1:0]    lvl_sum  [NUM_LVL];
  logic [WORD_W-1:0]   word_d;
  logic                valid_s1;

  // Stage 0: per-candidate thermometer decode with suppress/valid masking
  for (genvar c = 0; c < NUM_CAND; c++) begin : g_cand
    mtc_cand_decode #(.NUM_LVL(NUM_LVL), .CODE_W(CODE_W)) u_dec (
      .live  (in_valid),
      .sup   (cand_sup[c]),
      .code  (cand_code[c*CODE_W +: CODE_W]),
      .therm (therm[c])
    );
    for (genvar l = 0; l < NUM_LVL; l++) begin : g_tr
      assign lvl_hits[l][c] = therm[c][l];
    end
  end

  // Stage 1: registered per-level population count; stage 2 input: clamp
  for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
    mtc_level_count #(.NUM_CAND(NUM_CAND), .SUM_W(SUM_W)) u_cnt (
      .clk   (clk),
      .rst   (rst),
      .hits  (lvl_hits[l]),
      .sum_q (lvl_sum[l])
    );
    mtc_saturate #(.SUM_W(SUM_W), .CNT_W(CNT_W)) u_sat (
      .raw (lvl_sum[l]),
      .cnt (word_d[l*CNT_W +: CNT_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_s1   <= 1'b0;
      mult_valid <= 1'b0;
      mult_word  <= '0;
    end else begin
      valid_s1   <= in_valid;
      mult_valid <= valid_s1;
      mult_word  <= word_d;
    end
  end
endmodule

// File: rtl/thr_mult_counter_checker.sv
module thr_mult_counter_checker #(
  parameter int unsigned NUM_CAND = mtc_pkg::DEF_NUM_CAND,
  parameter int unsigned NUM_LVL  = mtc_pkg::DEF_NUM_LVL,
  parameter int unsigned CODE_W   = mtc_pkg::DEF_CODE_W,
  parameter int unsigned CNT_W    = mtc_pkg::DEF_CNT_W
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       in_valid,
  input logic [NUM_CAND*CODE_W-1:0] cand_code,
  input logic [NUM_CAND-1:0]        cand_sup,
  input logic [NUM_LVL*CNT_W-1:0]   mult_word,
  input logic                       mult_valid
);
  logic       seen_rst = 1'b0;
  logic [1:0] cyc      = 2'd0;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_rst <= 1'b1;
      cyc      <= 2'd0;
    end else if (cyc != 2'd3) begin
      cyc <= cyc + 2'd1;
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!seen_rst)
    $past(rst) |-> (!mult_valid && mult_word == '0)); // R1

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst || !seen_rst)
    (cyc >= 2'd2) |-> (mult_valid == $past(in_valid, 2))); // R2

  AST_NULL_CODES: assert property (@(posedge clk) disable iff (rst || !seen_rst)
    ((cyc >= 2'd2) && $past(cand_code == '0, 2)) |-> (mult_word == '0)); // R4

  AST_ALL_SUPPRESSED: assert property (@(posedge clk) disable iff (rst || !seen_rst)
    ((cyc >= 2'd2) && $past(&cand_sup, 2)) |-> (mult_word == '0)); // R5

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst || !seen_rst)
    !mult_valid |-> (mult_word == '0)); // R8

  for (genvar l = 0; l + 1 < NUM_LVL; l++) begin : g_ord
    AST_LEVEL_ORDER: assert property (@(posedge clk) disable iff (rst || !seen_rst)
      mult_word[(l+1)*CNT_W +: CNT_W] <= mult_word[l*CNT_W +: CNT_W]); // R9
  end
endmodule

bind thr_mult_counter thr_mult_counter_checker #(
  .NUM_CAND(NUM_CAND), .NUM_LVL(NUM_LVL), .CODE_W(CODE_W), .CNT_W(CNT_W)
) u_chk (.*);

// File: tb/thr_mult_counter_bench.sv
`timescale 1ns/1ps
module thr_mult_counter_bench;
  localparam int NC = 26;
  localparam int NL = 6;
  localparam int CW = 3;
  localparam int KW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [NC*CW-1:0] cand_code = '0;
  logic [NC-1:0]    cand_sup  = '0;
  logic [NL*KW-1:0] mult_word;
  logic             mult_valid;

  always #2 clk = ~clk;

  thr_mult_counter u_thr_mult_counter (
    .clk(clk), .rst(rst), .in_valid(in_valid), .cand_code(cand_code),
    .cand_sup(cand_sup), .mult_word(mult_word), .mult_valid(mult_valid)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  string cur_tag = "R1";

  logic [2:0] codes [NC];
  logic       sups  [NC];
  logic [NL*KW-1:0] exp1_w = '0, exp2_w = '0;
  logic             exp1_v = 1'b0, exp2_v = 1'b0;

  function automatic logic [NL*KW-1:0] model(input logic v);
    logic [NL*KW-1:0] w = '0;
    if (!v) return w;
    for (int lv = 1; lv <= NL; lv++) begin
      int n = 0;
      for (int c = 0; c < NC; c++)
        if (!sups[c] && codes[c] >= 1 && codes[c] <= NL && codes[c] >= lv) n++;
      if (n > 7) n = 7;
      w[(lv-1)*KW +: KW] = n[KW-1:0];
    end
    return w;
  endfunction

  task automatic tick();
    @(negedge clk);
    checks++;
    if (mult_word !== exp2_w || mult_valid !== exp2_v) begin
      fails++;
      $display("FAIL %s: word=%o valid=%b expected word=%o valid=%b",
               cur_tag, mult_word, mult_valid, exp2_w, exp2_v);
    end
    checks++; // R9 level ordering seen at the ports
    for (int l = 0; l + 1 < NL; l++) begin
      if (mult_word[(l+1)*KW +: KW] > mult_word[l*KW +: KW]) begin
        fails++;
        $display("FAIL R9: word=%o level %0d above level %0d expected nonincreasing",
                 mult_word, l + 2, l + 1);
        break;
      end
    end
    exp2_w = exp1_w;
    exp2_v = exp1_v;
  endtask

  task automatic drive(input logic v);
    for (int c = 0; c < NC; c++) begin
      cand_code[c*CW +: CW] = codes[c];
      cand_sup[c] = sups[c];
    end
    in_valid = v;
    exp1_w = model(v);
    exp1_v = v;
  endtask

  task automatic clear_cands();
    for (int c = 0; c < NC; c++) begin
      codes[c] = 3'd0;
      sups[c]  = 1'b0;
    end
  endtask

  task automatic check_lit(input string tag, input logic [NL*KW-1:0] w, input logic v);
    checks++;
    if (mult_word !== w || mult_valid !== v) begin
      fails++;
      $display("FAIL %s: word=%o valid=%b expected word=%o valid=%b",
               tag, mult_word, mult_valid, w, v);
    end
  endtask

  // one valid crossing, then an idle crossing carrying the same data
  task automatic run_lit(input string tag, input logic [NL*KW-1:0] w);
    cur_tag = tag;
    tick(); drive(1'b1);
    tick(); drive(1'b0);
    tick(); check_lit(tag, w, 1'b1);
    drive(1'b0);
    tick(); check_lit("R8", '0, 1'b0);
  endtask

  initial begin
    clear_cands();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check_lit("R1", '0, 1'b0);

    clear_cands(); codes[5] = 3'd1;
    run_lit("R7", 18'o000001);
    clear_cands(); codes[0] = 3'd2; codes[25] = 3'd2;
    run_lit("R7", 18'o000022);
    clear_cands(); codes[3] = 3'd6; codes[11] = 3'd4;
    run_lit("R3", 18'o112222);
    clear_cands();
    for (int c = 0; c < NC; c += 2) codes[c] = 3'd7;
    run_lit("R4", 18'o000000);
    clear_cands();
    for (int c = 0; c < NC; c++) begin codes[c] = 3'd6; sups[c] = (c % 9) != 4; end
    run_lit("R5", 18'o333333);
    clear_cands();
    for (int c = 0; c < NC; c++) begin codes[c] = 3'd6; sups[c] = 1'b1; end
    run_lit("R5", 18'o000000);
    clear_cands();
    for (int c = 0; c < NC; c++) codes[c] = 3'd6;
    run_lit("R6", 18'o777777);
    clear_cands();
    for (int c = 0; c < 10; c++) codes[c] = 3'd3;
    run_lit("R6", 18'o000777);

    cur_tag = "R10";
    for (int k = 0; k < 400; k++) begin
      tick();
      for (int c = 0; c < NC; c++) begin
        codes[c] = 3'($urandom_range(0, 7));
        sups[c]  = ($urandom_range(0, 3) == 0);
      end
      drive(($urandom_range(0, 4) != 0));
    end

    cur_tag = "R2";
    for (int k = 0; k < 40; k++) begin
      tick();
      clear_cands();
      codes[k % NC] = 3'(1 + k % 6);
      drive(k[0]);
    end
    tick(); clear_cands(); drive(1'b0);
    tick(); tick();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R2: watchdog expired, actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule